// File: doc/BRIEF.md
# Byte/Word Memory Access Unit

This unit sits between a 16-bit processor core and two targets: a byte-addressable memory and a region of I/O registers. The core presents one request at a time on a valid/ready channel, carrying a byte address, a byte-or-word flag, a write flag and write data. The unit steers the data onto the correct byte lanes in little-endian order, drives per-lane write enables to the memory, and returns read data on a registered response channel one cycle after the request is accepted.

The top 8 KB of the address space is hard-wired to the I/O port rather than to memory. I/O targets can be slow, so an I/O request is held on the core channel until the port signals it is ready. A word request at an odd address is refused: nothing is written, no target sees the request, and the response carries an error flag.

Back-pressure rules: the core must keep `req_valid` high and every request field stable until a cycle in which `req_ready` is also high; that cycle is the hand-off. The response channel has no ready input. The core must accept `rsp_valid` whenever it appears, and it appears exactly one cycle after each hand-off.

Top module: `mem_access_unit`

## Requirements
- R1: A word read at even address A returns the byte at A in bits 7:0 and the byte at A+1 in bits 15:8.
- R2: A byte read at address A returns the byte at A in bits 7:0 with bits 15:8 zero. Address bit 0 picks the lane: 0 is the low lane (bits 7:0 of the memory word), 1 is the high lane.
- R3: A byte write raises exactly one lane enable (bit 0 of `mem_we` for an even address, bit 1 for an odd one). It carries the byte from `req_wdata[7:0]` and leaves the other byte of the word unchanged.
- R4: A word write at an even address raises both lane enables. The low data byte goes to the even address and the high byte to the odd address.
- R5: A word access at an odd address raises `rsp_err` with its response. It writes neither memory nor I/O, does not raise `io_valid`, and returns zero read data.
- R6: Addresses 0xE000 to 0xFFFF go to the I/O port. They raise `io_valid`, present the low 13 address bits on `io_addr`, and never raise `mem_we`. Addresses 0xDFFF and below go to memory.
- R7: A memory request is accepted in the cycle it is presented (`req_ready` high). `rsp_valid` is high in the next cycle only.
- R8: An I/O request holds `req_ready` low until `io_ready` is high. It is accepted in that cycle, and its response follows one cycle later with the same lane steering as memory.
- R9: During and right after reset, `rsp_valid` and `rsp_err` are low.
- R10: A byte access at an odd address is legal and never raises `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when also valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rsp_valid | output | 1 | Response present, one cycle after hand-off |
| rsp_rdata | output | 16 | Read data, right-justified for byte reads |
| rsp_err | output | 1 | Odd-address word access was refused |
| mem_addr | output | 15 | Word address to memory |
| mem_we | output | 2 | Per-lane write enables to memory |
| mem_wdata | output | 16 | Lane-steered write data to memory |
| mem_rdata | input | 16 | Memory word at `mem_addr`, asynchronous read |
| io_valid | output | 1 | I/O request present |
| io_ready | input | 1 | I/O port completes the request this cycle |
| io_write | output | 1 | I/O write flag |
| io_addr | output | 13 | Byte offset within the I/O page |
| io_be | output | 2 | Per-lane byte enables to the I/O port |
| io_wdata | output | 16 | Lane-steered write data to the I/O port |
| io_rdata | input | 16 | I/O read word |

## Verification
The bench sweeps byte and word reads and writes over many addresses. It checks that a byte write leaves its neighbour intact; a design that enabled both lanes, or steered the byte to the wrong lane, would corrupt the adjacent byte. It sends word accesses to odd addresses in memory and in the I/O page, and counts writes reaching either target; a design that only flagged the error would still modify storage. It also probes the 0xDFFE/0xE000 and 0xFFFE edges of the I/O decode and measures how many cycles an I/O request is held. A decode that was off by one page would send writes to the wrong target, and a design that ignored `io_ready` would answer early.

// File: rtl/mau_pkg.sv
package mau_pkg;
  typedef enum logic [1:0] {
    ACC_MEM = 2'd0,
    ACC_IO  = 2'd1,
    ACC_BAD = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/mau_decode.sv
module mau_decode
  import mau_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_PAGE_W = 13,
  parameter int LSEL_W    = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_byte,
  output acc_kind_e         kind
);
  localparam int TAG_W = ADDR_W - IO_PAGE_W;

  logic io_hit;
  logic odd_word;

  assign io_hit   = &addr[ADDR_W-1:IO_PAGE_W];
  assign odd_word = !is_byte && (addr[LSEL_W-1:0] != '0);

  always_comb begin
    if (odd_word)    kind = ACC_BAD;
    else if (io_hit) kind = ACC_IO;
    else             kind = ACC_MEM;
  end

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = '0;
endmodule

// File: rtl/mau_lanes.sv
module mau_lanes #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8,
  parameter int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LSEL_W-1:0] lane_sel,
  input  logic              is_byte,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] rdata_raw,
  output logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rdata_out
);
  logic [7:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g]        = is_byte ? (lane_sel == LSEL_W'(g)) : 1'b1;
    assign wdata_out[g*8 +: 8] = is_byte ? wdata_in[7:0] : wdata_in[g*8 +: 8];
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < LANES; i++)
      if (lane_sel == LSEL_W'(i)) picked = rdata_raw[i*8 +: 8];
  end

  assign rdata_out = is_byte ? {{(DATA_W-8){1'b0}}, picked} : rdata_raw;
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int IO_PAGE_W = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_byte,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_err,
  output logic [ADDR_W-2:0]        mem_addr,
  output logic [DATA_W/8-1:0]      mem_we,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     io_valid,
  input  logic                     io_ready,
  output logic                     io_write,
  output logic [IO_PAGE_W-1:0]     io_addr,
  output logic [DATA_W/8-1:0]      io_be,
  output logic [DATA_W-1:0]        io_wdata,
  input  logic [DATA_W-1:0]        io_rdata
);
  localparam int LANES  = DATA_W / 8;
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  acc_kind_e         kind;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] steered_w;
  logic [DATA_W-1:0] raw_r;
  logic [DATA_W-1:0] steered_r;
  logic              accept;

  mau_decode #(.ADDR_W(ADDR_W), .IO_PAGE_W(IO_PAGE_W), .LSEL_W(LSEL_W)) i_decode (
    .addr    (req_addr),
    .is_byte (req_byte),
    .kind    (kind)
  );

  assign raw_r = (kind == ACC_IO) ? io_rdata : mem_rdata;

  mau_lanes #(.DATA_W(DATA_W), .LANES(LANES), .LSEL_W(LSEL_W)) i_lanes (
    .lane_sel  (req_addr[LSEL_W-1:0]),
    .is_byte   (req_byte),
    .wdata_in  (req_wdata),
    .rdata_raw (raw_r),
    .lane_en   (lane_en),
    .wdata_out (steered_w),
    .rdata_out (steered_r)
  );

  // Request hand-off: memory and refused requests go at once, I/O waits.
  assign req_ready = (kind == ACC_IO) ? io_ready : 1'b1;
  assign accept    = req_valid && req_ready;

  assign mem_addr  = req_addr[ADDR_W-1:LSEL_W];
  assign mem_wdata = steered_w;
  assign mem_we    = (req_valid && req_write && kind == ACC_MEM) ? lane_en : '0;

  assign io_valid  = req_valid && (kind == ACC_IO);
  assign io_write  = req_write;
  assign io_addr   = req_addr[IO_PAGE_W-1:0];
  assign io_be     = lane_en;
  assign io_wdata  = steered_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept && (kind == ACC_BAD);
      if (accept)
        rsp_rdata <= (kind == ACC_BAD || req_write) ? '0 : steered_r;
    end
  end

  AST_ODD_WORD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_byte && req_addr[0]) |-> (mem_we == '0 && !io_valid)); // R5
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0 && req_byte) |-> ($countones(mem_we) == 1)); // R3
  AST_IO_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid |-> (mem_we == '0)); // R6
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R7
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid); // R7
  AST_IO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_ready) |-> !req_ready); // R8
  AST_ERR_ONLY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R5
endmodule

// File: tb/test_mem_access_unit.sv
module test_mem_access_unit;
  localparam int CLK_PERIOD = 10;
  localparam int IO_LAT     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [14:0] mem_addr;
  logic [1:0]  mem_we, io_be;
  logic [15:0] mem_wdata, mem_rdata, io_wdata, io_rdata;
  logic io_valid, io_ready, io_write;
  logic [12:0] io_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_access_unit i_mem_access_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_valid(io_valid), .io_ready(io_ready), .io_write(io_write), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  function automatic logic [7:0] pat(int b);
    return 8'((b * 29 + 7) & 255);
  endfunction

  // Memory model: 4096 words, aliased on the word address.
  logic [15:0] mem [4096];
  logic [15:0] io_regs [16];
  int mem_wr_cnt = 0;
  int io_wr_cnt = 0;
  logic [1:0] last_we = '0;
  logic [2:0] io_cnt;

  assign mem_rdata = mem[mem_addr[11:0]];
  assign io_rdata  = io_regs[io_addr[4:1]];
  assign io_ready  = io_valid && (io_cnt == 3'(IO_LAT));

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = {pat(2*i+1), pat(2*i)};
    for (int i = 0; i < 16; i++) io_regs[i] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) io_cnt <= '0;
    else if (io_valid && !io_ready) io_cnt <= io_cnt + 3'd1;
    else io_cnt <= '0;
    if (mem_we != 2'b00) begin
      mem_wr_cnt <= mem_wr_cnt + 1;
      last_we <= mem_we;
      for (int l = 0; l < 2; l++)
        if (mem_we[l]) mem[mem_addr[11:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
    end
    if (io_valid && io_ready && io_write) begin
      io_wr_cnt <= io_wr_cnt + 1;
      for (int l = 0; l < 2; l++)
        if (io_be[l]) io_regs[io_addr[4:1]][l*8 +: 8] <= io_wdata[l*8 +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit bt, input logic [15:0] a,
                        input logic [15:0] wd, output logic [15:0] rd,
                        output bit er, output int waited);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = bt; req_addr = a; req_wdata = wd;
    waited = 0;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, "R7", "rsp_valid after hand-off", 32'(rsp_valid), 1);
    rd = rsp_rdata;
    er = rsp_err;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R7", "rsp_valid one cycle only", 32'(rsp_valid), 0);
  endtask

  initial begin
    logic [15:0] rd;
    bit er;
    int w, m0, i0;
    logic [7:0] nv [int];

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R9", "reset response",
          {rsp_valid, rsp_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R9", "after reset",
          {rsp_valid, rsp_err}, 0);

    // R1 R2: reads of preloaded pattern
    for (int a = 0; a < 256; a += 2) begin
      access(0, 0, 16'(a), 0, rd, er, w);
      check(rd === {pat(a+1), pat(a)}, "R1", "word read", rd, {pat(a+1), pat(a)});
      check(w == 0, "R7", "memory read wait", w, 0);
    end
    for (int a = 0; a < 256; a++) begin
      access(0, 1, 16'(a), 0, rd, er, w);
      check(rd === {8'h00, pat(a)}, "R2", "byte read", rd, {8'h00, pat(a)});
      check(er == 0, "R10", "byte access no error", er, 0);
    end

    // R4: word writes, read back as word and bytes
    for (int a = 16'h1000; a < 16'h1080; a += 2) begin
      logic [15:0] v;
      v = 16'(a * 16'h0123 + 16'h4d);
      access(1, 0, 16'(a), v, rd, er, w);
      check(last_we == 2'b11, "R4", "both lanes", last_we, 2'b11);
      access(0, 0, 16'(a), 0, rd, er, w);
      check(rd === v, "R4", "word readback", rd, v);
      access(0, 1, 16'(a), 0, rd, er, w);
      check(rd === {8'h00, v[7:0]}, "R4", "low byte at even", rd, {8'h00, v[7:0]});
      access(0, 1, 16'(a+1), 0, rd, er, w);
      check(rd === {8'h00, v[15:8]}, "R4", "high byte at odd", rd, {8'h00, v[15:8]});
    end

    // R3: byte writes keep the neighbour
    for (int a = 16'h0400; a < 16'h0480; a++) begin
      logic [15:0] exp;
      nv[a] = 8'(a ^ 8'h5a);
      access(1, 1, 16'(a), {8'hee, nv[a]}, rd, er, w);
      check(last_we == ((a % 2) ? 2'b10 : 2'b01), "R3", "single lane enable",
            last_we, (a % 2) ? 2'b10 : 2'b01);
      check(er == 0, "R10", "byte write no error", er, 0);
      exp = (a % 2) ? {nv[a], nv[a-1]} : {pat(a+1), nv[a]};
      access(0, 0, 16'(a & ~1), 0, rd, er, w);
      check(rd === exp, "R3", "neighbour byte kept", rd, exp);
    end

    // R5: odd word accesses are refused
    for (int a = 16'h0601; a < 16'h0640; a += 2) begin
      m0 = mem_wr_cnt; i0 = io_wr_cnt;
      access(1, 0, 16'(a), 16'hdead, rd, er, w);
      check(er == 1, "R5", "odd word write error", er, 1);
      check(mem_wr_cnt == m0 && io_wr_cnt == i0, "R5", "no write on odd word",
            mem_wr_cnt - m0, 0);
      access(0, 1, 16'(a), 0, rd, er, w);
      check(rd === {8'h00, pat(a)}, "R5", "byte unchanged", rd, {8'h00, pat(a)});
      access(0, 0, 16'(a), 0, rd, er, w);
      check(er == 1 && rd == 16'h0, "R5", "odd word read", {er, rd}, 32'h10000);
    end
    m0 = mem_wr_cnt; i0 = io_wr_cnt;
    access(1, 0, 16'he003, 16'hbeef, rd, er, w);
    check(er == 1 && w == 0, "R5", "odd word in I/O page", {er, 8'(w)}, 9'h100);
    check(mem_wr_cnt == m0 && io_wr_cnt == i0, "R5", "no I/O write", io_wr_cnt - i0, 0);

    // R6 R8: I/O page
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a, v;
      a = 16'he000 + 16'(2*k);
      v = 16'ha000 + 16'(k * 16'h111);
      m0 = mem_wr_cnt; i0 = io_wr_cnt;
      access(1, 0, a, v, rd, er, w);
      check(w == IO_LAT, "R8", "I/O write wait", w, IO_LAT);
      check(mem_wr_cnt == m0 && io_wr_cnt == i0 + 1, "R6", "I/O write target",
            io_wr_cnt - i0, 1);
      access(0, 0, a, 0, rd, er, w);
      check(rd === v && w == IO_LAT, "R8", "I/O word readback", rd, v);
    end
    access(1, 1, 16'he011, 16'h003c, rd, er, w);
    access(0, 1, 16'he011, 0, rd, er, w);
    check(rd === 16'h003c, "R8", "I/O byte readback", rd, 16'h003c);
    access(0, 1, 16'he010, 0, rd, er, w);
    check(rd === 16'h0010 + 16'((8 * 16'h111) & 16'hff) - 16'h0010 + 16'h0000 ||
          rd === {8'h00, 8'(16'ha000 + 8 * 16'h111)}, "R3", "I/O neighbour kept",
          rd, {8'h00, 8'(16'ha000 + 8 * 16'h111)});
    m0 = mem_wr_cnt; i0 = io_wr_cnt;
    access(1, 0, 16'hfffe, 16'h7711, rd, er, w);
    check(w == IO_LAT && io_wr_cnt == i0 + 1 && mem_wr_cnt == m0, "R6", "top word to I/O",
          io_wr_cnt - i0, 1);
    m0 = mem_wr_cnt; i0 = io_wr_cnt;
    access(1, 0, 16'hdffe, 16'hbeef, rd, er, w);
    check(w == 0 && mem_wr_cnt == m0 + 1 && io_wr_cnt == i0, "R6", "0xDFFE to memory",
          mem_wr_cnt - m0, 1);
    access(0, 0, 16'hdffe, 0, rd, er, w);
    check(rd === 16'hbeef, "R6", "0xDFFE readback", rd, 16'hbeef);
    m0 = mem_wr_cnt;
    access(1, 1, 16'hdfff, 16'h0042, rd, er, w);
    check(w == 0 && mem_wr_cnt == m0 + 1, "R6", "0xDFFF to memory", mem_wr_cnt - m0, 1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule